// File: doc/BRIEF.md
# Programmable CRC-32 Register Engine

This block is a CRC-32 engine that a processor reaches through a small 32-bit register bus with per-byte write strobes. Software loads a starting value and a generator polynomial. It then restarts the engine through the control register and pushes data into the data register. Each write folds either one byte or one 32-bit word into the running remainder, and the engine accepts one write per clock. A read of the data register returns the running remainder. A complement or any other finishing step is left to software.

Two reversal stages sit around the update logic, and each can be changed at any point in a computation. The input stage can mirror the bits of each byte, or mirror a whole word, before the data is folded in. The output stage can mirror the 32-bit remainder when it is read. A control write that does not request a restart changes only these modes, so software can feed an unaligned head as bytes, the body as words and the tail as bytes, all within one checksum.

Top module: `crcx_engine`

## Requirements
- R1: After a synchronous active-low reset, the data register reads 0xFFFFFFFF, the start value reads 0xFFFFFFFF, the polynomial reads 0x04C11DB7 and the control register reads 0.
- R2: The register offsets are data 0x00, control 0x08, start value 0x10 and polynomial 0x14. A control write with lane 0 enabled and bit 0 set loads the running CRC from the start value. Bit 0 always reads back as 0.
- R3: A data write with all four strobes set folds the 32-bit word MSB-first. The feed bit is the data bit XOR crc[31], and the polynomial is XORed in when the feed bit is 1. The result is readable in the cycle after the write, with no final XOR.
- R4: A data write with exactly one strobe set folds that lane's byte MSB-first (bit 7 first).
- R5: Control bits [6:5] select the input mode. With 01, each byte is bit-mirrored before folding. With 11, a word write is mirrored across all 32 bits and a byte write is mirrored across its 8 bits. With 00 or 10, data is folded as written.
- R6: When control bit 7 is set, a data read returns the running CRC with bit i moved to bit 31-i.
- R7: A control write with bit 0 clear changes only the modes and leaves the running CRC unchanged, so byte and word phases can be mixed in one computation.
- R8: The polynomial register holds the 32 coefficients in normal order, with x^32 implied, and can be changed at run time. Reflected input and output with start 0xFFFFFFFF give standard CRC-32 (0x04C11DB7) and CRC-32C (0x1EDC6F41) once software complements the value it reads.
- R9: Two kinds of write leave the running CRC unchanged: a data write whose strobes are neither all set nor exactly one set, and a write to an unmapped offset.
- R10: Writes to the start-value and polynomial registers update only the byte lanes whose strobes are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write request for this cycle |
| bus_addr | input | 5 | Byte offset of the register accessed |
| bus_be | input | 4 | Byte strobes, one per lane |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, valid in the same cycle |

## Verification
The assertions assume that only one register is written per cycle and that the address and strobes are stable while bus_wr is high. They also assume that restart requests come only through control writes. The bench meets these conditions by driving a single write per task on the falling edge and holding bus_wr low between writes. It changes modes only through control writes, so that every change in the remainder can be traced to a single data write or restart.

// File: rtl/crcx_pkg.sv
// Shared constants for the CRC engine: register offsets, field positions
// and reset values. Assumes a 32-bit remainder and a 32-bit data bus.
package crcx_pkg;
    localparam int CRC_W   = 32;
    localparam int LANES   = CRC_W / 8;

    localparam logic [7:0] OFF_DATA = 8'h00;
    localparam logic [7:0] OFF_CTRL = 8'h08;
    localparam logic [7:0] OFF_INIT = 8'h10;
    localparam logic [7:0] OFF_POLY = 8'h14;

    localparam int CTL_RESTART = 0;
    localparam int CTL_MODE_LO = 5;
    localparam int CTL_OUTREV  = 7;

    localparam logic [CRC_W-1:0] RST_INIT = 32'hFFFF_FFFF;
    localparam logic [CRC_W-1:0] RST_POLY = 32'h04C1_1DB7;

    typedef enum logic [1:0] {
        IN_PLAIN  = 2'b00,
        IN_BYTE   = 2'b01,
        IN_SPARE  = 2'b10,
        IN_WORD   = 2'b11
    } in_mode_e;
endpackage

// File: rtl/crcx_bitrev.sv
// Bit mirror inside groups of GRP bits across a W-bit vector.
// Assumes W is a multiple of GRP. Pure wiring, no logic.
module crcx_bitrev #(
    parameter int W   = 32,
    parameter int GRP = 8
) (
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    localparam int NGRP = W / GRP;

    // Mirror each group independently.
    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        for (genvar i = 0; i < GRP; i++) begin : g_bit
            assign dout[g*GRP + i] = din[g*GRP + GRP - 1 - i];
        end
    end
endmodule

// File: rtl/crcx_fold.sv
// Combinational fold of DW data bits into a CRC remainder, MSB first.
// Assumes the polynomial excludes the implicit top term.
module crcx_fold #(
    parameter int CW = 32,
    parameter int DW = 8
) (
    input  logic [CW-1:0] crc_in,
    input  logic [CW-1:0] poly,
    input  logic [DW-1:0] din,
    output logic [CW-1:0] crc_out
);
    // Shift through every data bit, highest first.
    always_comb begin
        logic [CW-1:0] acc;
        logic          fb;
        acc = crc_in;
        for (int i = DW - 1; i >= 0; i--) begin
            fb  = din[i] ^ acc[CW-1];
            acc = {acc[CW-2:0], 1'b0} ^ (fb ? poly : '0);
        end
        crc_out = acc;
    end
endmodule

// File: rtl/crcx_regs.sv
// Configuration registers: control modes, start value and polynomial.
// Produces a one-cycle restart request from a control write with bit 0 set.
// Assumes the top decodes nothing else at these offsets.
module crcx_regs
    import crcx_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [AW-1:0]    addr,
    input  logic [LANES-1:0] be,
    input  logic [CRC_W-1:0] wdata,
    output logic [CRC_W-1:0] init_q,
    output logic [CRC_W-1:0] poly_q,
    output in_mode_e         in_mode,
    output logic             out_rev,
    output logic             restart
);
    logic hit_ctrl, hit_init, hit_poly;

    // Address decode for the configuration registers.
    always_comb begin
        hit_ctrl = wr && (addr == AW'(OFF_CTRL));
        hit_init = wr && (addr == AW'(OFF_INIT));
        hit_poly = wr && (addr == AW'(OFF_POLY));
        restart  = hit_ctrl && be[0] && wdata[CTL_RESTART];
    end

    // Control fields, written through lane 0 only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_mode <= IN_PLAIN;
            out_rev <= 1'b0;
        end else if (hit_ctrl && be[0]) begin
            in_mode <= in_mode_e'(wdata[CTL_MODE_LO +: 2]);
            out_rev <= wdata[CTL_OUTREV];
        end
    end

    // Start value and polynomial, one byte lane at a time.
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                init_q[l*8 +: 8] <= RST_INIT[l*8 +: 8];
                poly_q[l*8 +: 8] <= RST_POLY[l*8 +: 8];
            end else begin
                if (hit_init && be[l]) init_q[l*8 +: 8] <= wdata[l*8 +: 8];
                if (hit_poly && be[l]) poly_q[l*8 +: 8] <= wdata[l*8 +: 8];
            end
        end
    end
endmodule

// File: rtl/crcx_engine.sv
// Top of the CRC engine: data write decode, input mirroring, byte and word
// fold paths, running remainder and read mux with optional output mirror.
// Assumes one bus access per cycle; reads are combinational on bus_addr.
module crcx_engine
    import crcx_pkg::*;
#(
    parameter int AW = 5
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic [AW-1:0] bus_addr,
    input  logic [3:0]  bus_be,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata
);
    logic [CRC_W-1:0] init_q, poly_q, crc_q;
    in_mode_e         in_mode;
    logic             out_rev, restart;

    crcx_regs #(.AW(AW)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .addr(bus_addr),
        .be(bus_be), .wdata(bus_wdata), .init_q(init_q), .poly_q(poly_q),
        .in_mode(in_mode), .out_rev(out_rev), .restart(restart)
    );

    logic hit_data, word_wr, byte_wr;
    logic [7:0] lane_byte;

    // Classify a data write by its strobes and pick the active lane.
    always_comb begin
        hit_data  = bus_wr && (bus_addr == AW'(OFF_DATA));
        word_wr   = hit_data && (bus_be == 4'b1111);
        byte_wr   = hit_data && ($countones(bus_be) == 1);
        lane_byte = bus_wdata[7:0];
        for (int l = 0; l < LANES; l++)
            if (bus_be[l]) lane_byte = bus_wdata[l*8 +: 8];
    end

    logic [CRC_W-1:0] w_mirb, w_mirw, word_in;
    logic [7:0]       b_mir, byte_in;

    crcx_bitrev #(.W(CRC_W), .GRP(8))     u_rev_wb (.din(bus_wdata), .dout(w_mirb));
    crcx_bitrev #(.W(CRC_W), .GRP(CRC_W)) u_rev_ww (.din(bus_wdata), .dout(w_mirw));
    crcx_bitrev #(.W(8),     .GRP(8))     u_rev_b  (.din(lane_byte), .dout(b_mir));

    // Apply the selected input mode to both data widths.
    always_comb begin
        unique case (in_mode)
            IN_BYTE: word_in = w_mirb;
            IN_WORD: word_in = w_mirw;
            default: word_in = bus_wdata;
        endcase
        byte_in = in_mode[0] ? b_mir : lane_byte;
    end

    logic [CRC_W-1:0] crc_w, crc_b;
    crcx_fold #(.CW(CRC_W), .DW(CRC_W)) u_fold_w (
        .crc_in(crc_q), .poly(poly_q), .din(word_in), .crc_out(crc_w));
    crcx_fold #(.CW(CRC_W), .DW(8)) u_fold_b (
        .crc_in(crc_q), .poly(poly_q), .din(byte_in), .crc_out(crc_b));

    // Running remainder: restart, word fold or byte fold.
    always_ff @(posedge clk) begin
        if (!rst_n)       crc_q <= RST_INIT;
        else if (restart) crc_q <= init_q;
        else if (word_wr) crc_q <= crc_w;
        else if (byte_wr) crc_q <= crc_b;
    end

    logic [CRC_W-1:0] crc_mir;
    crcx_bitrev #(.W(CRC_W), .GRP(CRC_W)) u_rev_o (.din(crc_q), .dout(crc_mir));

    // Read mux by offset.
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == AW'(OFF_DATA))      bus_rdata = out_rev ? crc_mir : crc_q;
        else if (bus_addr == AW'(OFF_CTRL)) begin
            bus_rdata[CTL_MODE_LO +: 2] = in_mode;
            bus_rdata[CTL_OUTREV]       = out_rev;
        end
        else if (bus_addr == AW'(OFF_INIT)) bus_rdata = init_q;
        else if (bus_addr == AW'(OFF_POLY)) bus_rdata = poly_q;
    end
endmodule

// File: rtl/crcx_chk.sv
// Temporal checks on the CRC engine, bound into every instance.
module crcx_chk
    import crcx_pkg::*;
#(
    parameter int AW = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_wr,
    input logic [AW-1:0] bus_addr,
    input logic [3:0]    bus_be,
    input logic [31:0]   bus_wdata,
    input logic [31:0]   bus_rdata,
    input logic [31:0]   crc_q,
    input logic [31:0]   init_q
);
    // R2
    restart_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == AW'(OFF_CTRL) && bus_be[0] && bus_wdata[0])
        |=> crc_q == $past(init_q));
    // R2
    restart_reads_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == AW'(OFF_CTRL)) |-> !bus_rdata[0]);
    // R7
    mode_keeps_crc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == AW'(OFF_CTRL) && !bus_wdata[0]) |=> $stable(crc_q));
    // R9
    odd_strobe_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == AW'(OFF_DATA) && bus_be != 4'hF
         && $countones(bus_be) != 1) |=> $stable(crc_q));
    // R3
    idle_keeps_crc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_wr |=> $stable(crc_q));
endmodule

bind crcx_engine crcx_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .crc_q(crc_q), .init_q(init_q)
);

// File: tb/sim_crcx_engine.sv
module sim_crcx_engine;
    logic        clk = 0, rst_n = 0, bus_wr = 0;
    logic [4:0]  bus_addr = 0;
    logic [3:0]  bus_be = 0;
    logic [31:0] bus_wdata = 0, bus_rdata;
    int total = 0, bad = 0;
    logic [31:0] m_crc, m_poly, m_init;

    always #2 clk = ~clk;

    crcx_engine u0 (.clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
                    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

    function automatic logic [31:0] mir(input logic [31:0] v, input int n);
        logic [31:0] r = 0;
        for (int i = 0; i < n; i++) r[i] = v[n-1-i];
        return r;
    endfunction

    function automatic logic [31:0] msb_fold(input logic [31:0] c, input logic [31:0] p,
                                             input logic [31:0] d, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            logic f = d[i] ^ c[31];
            c = c << 1;
            if (f) c = c ^ p;
        end
        return c;
    endfunction

    // Conventional LSB-first reflected CRC over a byte queue, no final XOR.
    function automatic logic [31:0] refl_crc(input byte unsigned q[$], input logic [31:0] prev);
        logic [31:0] c = 32'hFFFF_FFFF;
        foreach (q[k]) begin
            c ^= {24'h0, q[k]};
            for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ prev) : (c >> 1);
        end
        return c;
    endfunction

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%08h exp=%08h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [3:0] be, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1; bus_addr = a; bus_be = be; bus_wdata = d;
        @(negedge clk);
        bus_wr = 0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] v);
        bus_addr = a; #1; v = bus_rdata;
    endtask

    // Feed a buffer with reflected input and output, words then bytes.
    task automatic feed(input byte unsigned q[$], output logic [31:0] res);
        int k = 0;
        wr(5'h08, 4'h1, 32'hE1);
        while (q.size() - k >= 4) begin
            wr(5'h00, 4'hF, {q[k+3], q[k+2], q[k+1], q[k]});
            k += 4;
        end
        wr(5'h08, 4'h1, 32'hA0);
        while (k < q.size()) begin
            wr(5'h00, 4'h1, {24'h0, q[k]});
            k++;
        end
        rd(5'h00, res);
    endtask

    initial begin
        #(4 * 200000);
        bad++; total++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        byte unsigned s9[$];
        byte unsigned rq[$];
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R1 reset values
        rd(5'h00, v); chk("R1 data", v, 32'hFFFF_FFFF);
        rd(5'h14, v); chk("R1 poly", v, 32'h04C1_1DB7);
        rd(5'h10, v); chk("R1 init", v, 32'hFFFF_FFFF);
        rd(5'h08, v); chk("R1 ctrl", v, 0);
        m_poly = 32'h04C1_1DB7;

        // R10 lane writes, R2 restart from start value
        wr(5'h10, 4'h3, 32'h1234_ABCD);
        rd(5'h10, v); chk("R10 init lanes", v, 32'hFFFF_ABCD);
        wr(5'h10, 4'hF, 32'h1357_9BDF); m_init = 32'h1357_9BDF;
        wr(5'h08, 4'h1, 32'h01);
        rd(5'h00, v); chk("R2 restart load", v, m_init);
        rd(5'h08, v); chk("R2 bit0 reads 0", v, 0);
        m_crc = m_init;

        // R3 word fold, plain mode
        wr(5'h00, 4'hF, 32'hDEAD_BEEF);
        m_crc = msb_fold(m_crc, m_poly, 32'hDEAD_BEEF, 32);
        rd(5'h00, v); chk("R3 word fold", v, m_crc);

        // R4 byte on lane 2
        wr(5'h00, 4'h4, 32'h00A5_0000);
        m_crc = msb_fold(m_crc, m_poly, 32'hA5, 8);
        rd(5'h00, v); chk("R4 lane2 byte", v, m_crc);

        // R9 ignored strobes and unmapped offset
        wr(5'h00, 4'h3, 32'h5555_5555);
        wr(5'h04, 4'hF, 32'h7777_7777);
        rd(5'h00, v); chk("R9 ignored writes", v, m_crc);

        // R7 mode change without restart, then R5 byte-mirror mode
        wr(5'h08, 4'h1, 32'h20);
        rd(5'h00, v); chk("R7 crc kept", v, m_crc);
        wr(5'h00, 4'h1, 32'h0000_0013);
        m_crc = msb_fold(m_crc, m_poly, mir(32'h13, 8), 8);
        rd(5'h00, v); chk("R5 byte mode byte", v, m_crc);
        wr(5'h00, 4'hF, 32'h0102_0380);
        m_crc = msb_fold(m_crc, m_poly, 32'h8040_C001, 32);
        rd(5'h00, v); chk("R5 byte mode word", v, m_crc);
        wr(5'h08, 4'h1, 32'h60);
        wr(5'h00, 4'hF, 32'h0000_0001);
        m_crc = msb_fold(m_crc, m_poly, 32'h8000_0000, 32);
        rd(5'h00, v); chk("R5 word mode", v, m_crc);
        wr(5'h08, 4'h1, 32'h40);
        wr(5'h00, 4'hF, 32'h0000_0001);
        m_crc = msb_fold(m_crc, m_poly, 32'h1, 32);
        rd(5'h00, v); chk("R5 spare mode plain", v, m_crc);

        // R6 output mirror
        wr(5'h08, 4'h1, 32'h80);
        rd(5'h00, v); chk("R6 out mirror", v, mir(m_crc, 32));

        // R8 standard check strings
        wr(5'h10, 4'hF, 32'hFFFF_FFFF);
        s9 = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};
        feed(s9, v); chk("R8 crc32 check", ~v, 32'hCBF4_3926);
        wr(5'h14, 4'hF, 32'h1EDC_6F41);
        feed(s9, v); chk("R8 crc32c check", ~v, 32'hE306_9283);
        for (int len = 1; len <= 11; len += 2) begin
            rq.delete();
            for (int j = 0; j < len; j++) rq.push_back(8'((j * 37 + len * 11) ^ 8'h5A));
            feed(rq, v); chk("R8 crc32c odd len", v, refl_crc(rq, 32'h82F6_3B78));
        end
        wr(5'h14, 4'hF, 32'h04C1_1DB7);
        for (int len = 2; len <= 10; len += 4) begin
            rq.delete();
            for (int j = 0; j < len; j++) rq.push_back(8'(j * 91 + 3));
            feed(rq, v); chk("R8 crc32 len", v, refl_crc(rq, 32'hEDB8_8320));
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule